// File: doc/BRIEF.md
# Nested Task Switch Controller

This block performs task switches in hardware for a small, fixed set of tasks. Each task owns a record in an internal register file. Word 0 of the record holds a back-link. The remaining words hold the task's saved context. A busy flag and a nested flag per task track which tasks belong to the active call chain. A request names a kind and a target. The controller checks it against the flags. A legal request then runs a sequencer that stores the live context of the outgoing task, one word per cycle, and loads the incoming task's saved words onto the context output, one word per cycle. Only after that does it update the current-task output.

A linked switch (call or interrupt) writes the outgoing task's index into the incoming task's back-link. A return follows that link and unwinds the chain. A plain jump writes no link and hands the busy flag from the outgoing task to the incoming one. An illegal request raises a one-cycle fault and leaves every piece of state untouched. Illegal requests are a linked switch or a jump to a task that is already busy, and a return from a task that was not entered through a link.

Top module: `tsc_nested_switch`

## Requirements
- R1: After reset, task 0 is current, `req_ready_o` is 1, `fault_o` is 0, `cur_link_o` is 0 and `ctx_o` is all zeros.
- R2: A request of kind 0 (CALL) to a task that is not busy makes that task current, and its back-link becomes the index of the task that issued the call.
- R3: A CALL (kind 0) or interrupt (kind 3) to a busy task is refused. A busy task here includes the current task. `fault_o` is high for one cycle, in the cycle after acceptance. `req_ready_o` stays high and the current task does not change.
- R4: A request of kind 2 (IRET) from a nested task switches to the task named in the current task's back-link, whatever `req_target_i` carries.
- R5: An IRET from a task whose nested flag is clear is refused with a one-cycle fault and no switch. A task's nested flag is set only when it is entered by CALL or interrupt, and it is cleared when that task is left by IRET or JMP.
- R6: A request of kind 1 (JMP) to a task that is not busy makes it current. It writes no back-link, so `cur_link_o` shows the value the target held before. It frees the outgoing task, so a later CALL to that task is accepted, and it leaves the incoming task not nested. A JMP to a busy task is refused with a fault.
- R7: A request of kind 3 (interrupt) behaves as a linked switch like CALL, so the handler task can return with IRET.
- R8: Across a legal switch, the live context words present during the transfer are stored in the outgoing task's record. `ctx_o` then shows the words last stored for the incoming task, or zeros if that task was never left.
- R9: After a legal request is accepted, `req_ready_o` is low for exactly 2*(CTX_WORDS-1) cycles. `cur_task_o` changes only in the cycle in which `req_ready_o` returns high.
- R10: The back-link is a 16-bit field in the low half of word 0 of each record, and `cur_link_o` shows it for the current task. The context ports carry record words 1 to CTX_WORDS-1, with port slice k holding word k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Switch request valid |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_kind_i | input | 2 | 0 CALL, 1 JMP, 2 IRET, 3 interrupt |
| req_target_i | input | TIDX_W (2) | Target task index (ignored for IRET) |
| ctx_live_i | input | (CTX_WORDS-1)*WORD_W (96) | Live context of the running task, sampled during the save phase |
| ctx_o | output | (CTX_WORDS-1)*WORD_W (96) | Context loaded for the current task |
| cur_task_o | output | TIDX_W (2) | Index of the current task |
| cur_link_o | output | 16 | Back-link field of the current task |
| fault_o | output | 1 | One-cycle pulse on a refused request |

## Verification
The hardest state to reach is a refusal that depends on history. Examples are a return from a task that was entered by a jump after it had once been nested, and a call to a task freed only by an earlier jump. The stimulus builds a three-deep chain with a jump and two linked switches, then probes it with refused calls and jumps to chain members and to the current task. It then unwinds the chain with returns whose target field is deliberately wrong. Further jumps then clear nested and busy flags, and a return from the jumped-to task must fault even though that task still carries a stale back-link. Each request uses a distinct live context pattern, so every load can be traced to the switch that saved it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int LINK_W = 16;

    typedef enum logic [1:0] {
        KIND_CALL = 2'd0,
        KIND_JMP  = 2'd1,
        KIND_IRET = 2'd2,
        KIND_INTR = 2'd3
    } sw_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tsc_ctx_store.sv
module tsc_ctx_store #(
    parameter int NUM_TASKS = 4,
    parameter int CTX_WORDS = 4,
    parameter int WORD_W    = 32,
    localparam int TIDX_W   = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
    localparam int WIDX_W   = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [TIDX_W-1:0] wr_task_i,
    input  logic [WIDX_W-1:0] wr_word_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [TIDX_W-1:0] rda_task_i,
    input  logic [WIDX_W-1:0] rda_word_i,
    output logic [WORD_W-1:0] rda_data_o,
    input  logic [TIDX_W-1:0] rdb_task_i,
    input  logic [WIDX_W-1:0] rdb_word_i,
    output logic [WORD_W-1:0] rdb_data_o
);

    logic [WORD_W-1:0] mem_q [NUM_TASKS][CTX_WORDS];
    logic [WORD_W-1:0] mem_d [NUM_TASKS][CTX_WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[wr_task_i][wr_word_i] = wr_data_i;
        end
    end

    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
        for (genvar w = 0; w < CTX_WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[t][w] <= '0;
                end else begin
                    mem_q[t][w] <= mem_d[t][w];
                end
            end
        end
    end

    assign rda_data_o = mem_q[rda_task_i][rda_word_i];
    assign rdb_data_o = mem_q[rdb_task_i][rdb_word_i];

    // R8
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> ({1'b0, wr_task_i} < (TIDX_W+1)'(NUM_TASKS)) &&
                    ({1'b0, wr_word_i} < (WIDX_W+1)'(CTX_WORDS)));

endmodule

// File: rtl/tsc_chain.sv
module tsc_chain
    import tsc_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    localparam int TIDX_W   = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_i,
    input  sw_kind_e             kind_i,
    input  logic [TIDX_W-1:0]    cur_i,
    input  logic [TIDX_W-1:0]    tgt_i,
    output logic [NUM_TASKS-1:0] busy_o,
    output logic [NUM_TASKS-1:0] nested_o
);

    typedef struct packed {
        logic [NUM_TASKS-1:0] busy;
        logic [NUM_TASKS-1:0] nested;
    } flags_t;

    flags_t d, q;

    always_comb begin
        d = q;
        if (upd_i) begin
            unique case (kind_i)
                KIND_CALL, KIND_INTR: begin
                    d.busy[tgt_i]   = 1'b1;
                    d.nested[tgt_i] = 1'b1;
                end
                KIND_JMP: begin
                    d.busy[cur_i]   = 1'b0;
                    d.nested[cur_i] = 1'b0;
                    d.busy[tgt_i]   = 1'b1;
                    d.nested[tgt_i] = 1'b0;
                end
                KIND_IRET: begin
                    d.busy[cur_i]   = 1'b0;
                    d.nested[cur_i] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy   <= NUM_TASKS'(1);
            q.nested <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign nested_o = q.nested;

    // R5
    nested_in_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.nested & ~q.busy) == '0);

    // R6
    some_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.busy) >= 1);

endmodule

// File: rtl/tsc_nested_switch.sv
module tsc_nested_switch
    import tsc_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    parameter int CTX_WORDS = 4,
    parameter int WORD_W    = 32,
    localparam int TIDX_W   = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
    localparam int WIDX_W   = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1,
    localparam int GP_WORDS = CTX_WORDS - 1,
    localparam int CTX_W    = GP_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_kind_i,
    input  logic [TIDX_W-1:0] req_target_i,
    input  logic [CTX_W-1:0]  ctx_live_i,
    output logic [CTX_W-1:0]  ctx_o,
    output logic [TIDX_W-1:0] cur_task_o,
    output logic [LINK_W-1:0] cur_link_o,
    output logic              fault_o
);

    typedef struct packed {
        seq_state_e                      state;
        logic [WIDX_W-1:0]               cnt;
        logic [TIDX_W-1:0]               cur;
        logic [TIDX_W-1:0]               tgt;
        logic                            fault;
        logic [GP_WORDS-1:0][WORD_W-1:0] ctx;
    } ctl_t;

    localparam logic [WIDX_W-1:0] LAST_CNT = WIDX_W'(GP_WORDS - 1);

    ctl_t d, q;

    sw_kind_e             req_kind;
    logic [NUM_TASKS-1:0] busy, nested;
    logic                 upd;
    logic [TIDX_W-1:0]    nxt;
    logic                 wr_en;
    logic [TIDX_W-1:0]    wr_task;
    logic [WIDX_W-1:0]    wr_word;
    logic [WORD_W-1:0]    wr_data;
    logic [WORD_W-1:0]    link_word;
    logic [WORD_W-1:0]    load_word;
    logic [WIDX_W-1:0]    rec_word;
    logic                 tgt_in_range;
    logic                 legal;
    logic                 link_word_unused;

    assign req_kind     = sw_kind_e'(req_kind_i);
    assign rec_word     = q.cnt + WIDX_W'(1);
    assign tgt_in_range = {1'b0, req_target_i} < (TIDX_W+1)'(NUM_TASKS);

    always_comb begin
        d       = q;
        d.fault = 1'b0;
        upd     = 1'b0;
        legal   = 1'b0;
        nxt     = req_target_i;
        wr_en   = 1'b0;
        wr_task = q.cur;
        wr_word = '0;
        wr_data = '0;

        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (req_kind == KIND_IRET) begin
                        legal = nested[q.cur];
                        nxt   = link_word[TIDX_W-1:0];
                    end else begin
                        legal = tgt_in_range && !busy[req_target_i];
                    end
                    if (legal) begin
                        upd     = 1'b1;
                        d.tgt   = nxt;
                        d.cnt   = '0;
                        d.state = ST_SAVE;
                        if (req_kind == KIND_CALL || req_kind == KIND_INTR) begin
                            wr_en   = 1'b1;
                            wr_task = req_target_i;
                            wr_word = '0;
                            wr_data = WORD_W'(q.cur);
                        end
                    end else begin
                        d.fault = 1'b1;
                    end
                end
            end
            ST_SAVE: begin
                wr_en   = 1'b1;
                wr_task = q.cur;
                wr_word = rec_word;
                wr_data = ctx_live_i[q.cnt*WORD_W +: WORD_W];
                if (q.cnt == LAST_CNT) begin
                    d.cnt   = '0;
                    d.state = ST_LOAD;
                end else begin
                    d.cnt = q.cnt + WIDX_W'(1);
                end
            end
            ST_LOAD: begin
                d.ctx[q.cnt] = load_word;
                if (q.cnt == LAST_CNT) begin
                    d.cnt   = '0;
                    d.cur   = q.tgt;
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + WIDX_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.cur   <= '0;
            q.tgt   <= '0;
            q.fault <= 1'b0;
            q.ctx   <= '0;
        end else begin
            q <= d;
        end
    end

    tsc_chain #(
        .NUM_TASKS (NUM_TASKS)
    ) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (upd),
        .kind_i   (req_kind),
        .cur_i    (q.cur),
        .tgt_i    (nxt),
        .busy_o   (busy),
        .nested_o (nested)
    );

    tsc_ctx_store #(
        .NUM_TASKS (NUM_TASKS),
        .CTX_WORDS (CTX_WORDS),
        .WORD_W    (WORD_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_task_i  (wr_task),
        .wr_word_i  (wr_word),
        .wr_data_i  (wr_data),
        .rda_task_i (q.cur),
        .rda_word_i ('0),
        .rda_data_o (link_word),
        .rdb_task_i (q.tgt),
        .rdb_word_i (rec_word),
        .rdb_data_o (load_word)
    );

    assign link_word_unused = ^link_word[WORD_W-1:LINK_W];

    assign req_ready_o = (q.state == ST_IDLE);
    assign ctx_o       = q.ctx;
    assign cur_task_o  = q.cur;
    assign cur_link_o  = link_word[LINK_W-1:0];
    assign fault_o     = q.fault;

    // R9
    cur_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_task_o) |-> req_ready_o && ($past(q.state) == ST_LOAD));

    // R9
    transfer_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready_o) |=> !req_ready_o);

    // R3
    fault_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> req_ready_o && $stable(cur_task_o));

    // R1
    current_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> busy[cur_task_o]);

endmodule

// File: tb/tsc_nested_switch_tb_top.sv
module tsc_nested_switch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT     = 4;
    localparam int CW     = 4;
    localparam int WW     = 32;
    localparam int GP     = CW - 1;
    localparam int TW     = 2;
    localparam int CTXW   = GP * WW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_kind = '0;
    logic [TW-1:0]   req_target = '0;
    logic [CTXW-1:0] ctx_live = '0;
    logic [CTXW-1:0] ctx_out;
    logic [TW-1:0]   cur_task;
    logic [15:0]     cur_link;
    logic            fault;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit              is_fault;
        int              cur;
        int              link;
        logic [CTXW-1:0] ctx;
        string           tag;
    } exp_t;

    exp_t exp_q[$];

    bit              m_busy[NT];
    bit              m_nested[NT];
    int              m_link[NT];
    logic [CTXW-1:0] m_saved[NT];
    int              m_cur;
    bit              rdy_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_nested_switch #(
        .NUM_TASKS (NT),
        .CTX_WORDS (CW),
        .WORD_W    (WW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_kind_i   (req_kind),
        .req_target_i (req_target),
        .ctx_live_i   (ctx_live),
        .ctx_o        (ctx_out),
        .cur_task_o   (cur_task),
        .cur_link_o   (cur_link),
        .fault_o      (fault)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_ctx(input logic [CTXW-1:0] act, input logic [CTXW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R8 ctx_o: actual 0x%0h expected 0x%0h", act, exp);
        end
    endtask

    // Monitor: pops one expected item per completion event
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault || (req_ready && !rdy_prev)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected completion", longint'(fault), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fault == e.is_fault, e.tag, "fault_o", longint'(fault),
                          longint'(e.is_fault));
                    check(int'(cur_task) == e.cur, e.tag, "cur_task_o",
                          longint'(cur_task), longint'(e.cur));
                    check(int'(cur_link) == e.link, {e.tag, " R10"}, "cur_link_o",
                          longint'(cur_link), longint'(e.link));
                    if (!e.is_fault) check_ctx(ctx_out, e.ctx);
                end
            end
            rdy_prev <= req_ready;
        end
    end

    // Driver: predicts the outcome from the requirements, then issues the request
    task automatic do_req(input int kind, input int tgt, input int seq, input string tag);
        exp_t e;
        bit   legal;
        int   nxt;
        int   low;
        for (int w = 0; w < GP; w++) ctx_live[w*WW +: WW] = (seq << 8) | w | 32'hA500_0000;
        if (kind == 2) begin
            legal = m_nested[m_cur];
            nxt   = m_link[m_cur];
        end else begin
            legal = !m_busy[tgt];
            nxt   = tgt;
        end
        if (legal) begin
            m_saved[m_cur] = ctx_live;
            case (kind)
                0, 3: begin
                    m_busy[nxt] = 1; m_nested[nxt] = 1; m_link[nxt] = m_cur;
                end
                1: begin
                    m_busy[m_cur] = 0; m_nested[m_cur] = 0;
                    m_busy[nxt] = 1; m_nested[nxt] = 0;
                end
                default: begin
                    m_busy[m_cur] = 0; m_nested[m_cur] = 0;
                end
            endcase
            m_cur = nxt;
        end
        e.is_fault = !legal;
        e.cur      = m_cur;
        e.link     = m_link[m_cur];
        e.ctx      = m_saved[m_cur];
        e.tag      = tag;
        exp_q.push_back(e);

        req_valid  = 1'b1;
        req_kind   = kind[1:0];
        req_target = tgt[TW-1:0];
        @(negedge clk);
        req_valid  = 1'b0;
        low = 0;
        while (!req_ready) begin
            low++;
            @(negedge clk);
        end
        // R9: ready low for 2*(CW-1) cycles on a legal switch, none on a refusal
        check(low == (legal ? 2*GP : 0), "R9", "ready low cycles",
              longint'(low), longint'(legal ? 2*GP : 0));
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NT; i++) begin
            m_busy[i] = (i == 0); m_nested[i] = 0; m_link[i] = 0; m_saved[i] = '0;
        end
        m_cur = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cur_task == 0, "R1", "cur_task_o", longint'(cur_task), 0);
        check(req_ready == 1'b1, "R1", "req_ready_o", longint'(req_ready), 1);
        check(fault == 1'b0, "R1", "fault_o", longint'(fault), 0);
        check(cur_link == 0, "R1", "cur_link_o", longint'(cur_link), 0);
        check(ctx_out == '0, "R1", "ctx_o zero", longint'(ctx_out[63:0]), 0);

        do_req(1, 2, 1,  "R6");   // JMP 0->2, no link
        do_req(0, 1, 2,  "R2");   // CALL 2->1, link 2
        do_req(3, 3, 3,  "R7");   // interrupt 1->3, link 1
        do_req(0, 2, 4,  "R3");   // CALL to chain member: refused
        do_req(3, 3, 5,  "R3");   // interrupt to current task: refused
        do_req(1, 1, 6,  "R6");   // JMP to busy task: refused
        do_req(2, 0, 7,  "R4");   // IRET, target field ignored, back to 1
        do_req(2, 3, 8,  "R4");   // IRET back to 2
        do_req(2, 1, 9,  "R5");   // IRET from non-nested 2: refused
        do_req(0, 0, 10, "R6");   // CALL to task 0 freed by the first JMP
        do_req(1, 3, 11, "R6");   // JMP 0->3, link of 3 stays 1
        do_req(2, 0, 12, "R5");   // IRET from 3 entered by JMP: refused
        do_req(3, 1, 13, "R7");   // interrupt 3->1, link 3
        do_req(2, 2, 14, "R7");   // handler returns to 3

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending expectations",
              longint'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule